// File: doc/BRIEF.md
# Peripheral Clock Divider with Source Select

This block produces the clock-enable pulses for seven peripheral clock domains: audio, serial, display pixel, card, USB host, display controller and USB device. Every channel takes its timing from one of two sources. One is an external reference tick. The other is a "PLL-half" tick, which is either the full PLL tick stream or every second PLL tick. On the PLL-half source, a channel divides by its programmed field plus one. On the external source, the divider is skipped and the channel repeats the reference tick. The audio, serial and USB device channels can select their source. The other four channels always run from the PLL-half tick.

A single-cycle register port writes and reads a control word, a 16-bit gate word and five divider words. In the gate word a set bit stops the matching clock, and the inverse of the gate word is driven out as a run vector. A suspend request stops the timer, DMA and UART0 clocks as a group, and a resume request restarts them. When a source select changes, the channel's output is held low until one tick of each source has passed. A new divider value takes effect only at the end of the current period.

Top module: `pclk_gen`

## Requirements
- R1: With the PLL-half source selected, a channel's `pclk_en` pulses once every (field+1) PLL-half ticks. The pixel (channel 2), card (3), USB host (4) and display controller (5) channels always use the PLL-half source.
- R2: When control bit 21 is 1, the PLL-half tick equals every `pll_tick`. When it is 0, the PLL-half tick is every second `pll_tick`.
- R3: With the external source selected, a channel's output repeats `ref_tick` and the divider field has no effect. The source selects are 1 for PLL-half and 0 for external: audio (channel 0) is control bit 31, USB device (channel 6) is control bit 29, and serial (channel 1) is bit 31 of register 3.
- R4: Register addresses and fields are: 0 control, 1 gate [15:0], 2 audio divider [8:0], 3 serial divider [3:0], 4 pixel divider [8:0], 5 card divider [4:0], 6 USB host divider [3:0], 7 reads zero. The USB device field is control [28:23]. Written bits above a field's width are dropped.
- R5: The display controller field is control [20:16]. A written value below the parameter `DISP_MIN_FIELD` (default 1) is stored as `DISP_MIN_FIELD`, so the display clock never exceeds PLL-half/(DISP_MIN_FIELD+1). The stored value is what reads back.
- R6: A 1 in a gate bit forces the matching `pclk_en` low from the next cycle on. The bits are audio 6, serial 4, card 7, USB host 14, display controller 10 and USB device 11. `clk_run` equals the inverse of the gate word.
- R7: The pixel channel has no gate bit and keeps running when every gate bit is set.
- R8: `suspend_req` sets gate bits 0, 1 and 12 (UART0, timer, DMA). `resume_req` clears those three bits. No other gate bit changes, and suspend wins when both requests arrive together.
- R9: After a channel's source select changes, its `pclk_en` stays low for at least the two following cycles. It then stays low until one `ref_tick` and one PLL-half tick have both been seen.
- R10: A divider write made in the middle of a period does not change that period. The new value applies from the next terminal count.
- R11: Reset clears every register, except the display field, which resets to `DISP_MIN_FIELD`. Reset drives `pclk_en` to 0 and `clk_run` to all ones.
- R12: `pclk_en` is registered and pulses in the cycle after the source tick that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_tick | input | 1 | PLL tick, one cycle wide |
| ref_tick | input | 1 | External reference tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| suspend_req | input | 1 | Stop the timer, DMA and UART0 clocks |
| resume_req | input | 1 | Restart the timer, DMA and UART0 clocks |
| pclk_en | output | 7 | Per-channel clock-enable pulses |
| clk_run | output | 16 | Inverted gate word, 1 = clock runs |

## Verification
The assertions are checked on every cycle. They cover the effect of suspend and resume on the grouped gate bits, gated channels staying silent, the display field never falling below its floor, and a channel staying quiet right after its source changes. Only the bench scenarios can show output periods under each combination of source, half select and field. The same goes for the reference bypass, field truncation, and a new divider value taking effect at the period boundary rather than part-way through it.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int NCH  = 7;
    localparam int DW   = 32;
    localparam int GW   = 16;
    localparam int AW   = 3;
    localparam int FMAX = 9;

    // channel indices
    localparam int CH_AUD   = 0;
    localparam int CH_SER   = 1;
    localparam int CH_PIX   = 2;
    localparam int CH_CARD  = 3;
    localparam int CH_UHOST = 4;
    localparam int CH_DISP  = 5;
    localparam int CH_UDEV  = 6;

    typedef enum logic [AW-1:0] {
        RA_CTRL  = 3'd0,
        RA_GATE  = 3'd1,
        RA_AUD   = 3'd2,
        RA_SER   = 3'd3,
        RA_PIX   = 3'd4,
        RA_CARD  = 3'd5,
        RA_UHOST = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    // control word bit positions
    localparam int B_AUD_SRC   = 31;
    localparam int B_UDEV_SRC  = 29;
    localparam int B_HALF_FULL = 21;
    localparam int L_UDEV      = 23;
    localparam int L_DISP      = 16;
    localparam int B_SER_SRC   = 31;

    // gate bits set by suspend: UART0, timer, DMA
    localparam logic [GW-1:0] SLEEP_SET = 16'h1003;

    typedef struct packed {
        logic            pll_src;
        logic            gated;
        logic [FMAX-1:0] field;
    } chan_cfg_t;

    function automatic int fld_w(input int ch);
        case (ch)
            CH_AUD:   return 9;
            CH_SER:   return 4;
            CH_PIX:   return 9;
            CH_CARD:  return 5;
            CH_UHOST: return 4;
            CH_DISP:  return 5;
            default:  return 6;
        endcase
    endfunction

    function automatic logic [GW-1:0] gate_mask(input int ch);
        case (ch)
            CH_AUD:   return 16'h0040;
            CH_SER:   return 16'h0010;
            CH_PIX:   return 16'h0000;
            CH_CARD:  return 16'h0080;
            CH_UHOST: return 16'h4000;
            CH_DISP:  return 16'h0400;
            default:  return 16'h0800;
        endcase
    endfunction

    function automatic bit fixed_pll(input int ch);
        return !(ch == CH_AUD || ch == CH_SER || ch == CH_UDEV);
    endfunction

endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
#(
    parameter int DISP_MIN_FIELD = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    input  logic                   suspend_req,
    input  logic                   resume_req,
    output logic                   half_full,
    output logic [GW-1:0]          gate_q,
    output chan_cfg_t [NCH-1:0]    cfg
);

    localparam int AUDW   = fld_w(CH_AUD);
    localparam int SERW   = fld_w(CH_SER);
    localparam int PIXW   = fld_w(CH_PIX);
    localparam int CARDW  = fld_w(CH_CARD);
    localparam int UHOSTW = fld_w(CH_UHOST);
    localparam int DISPW  = fld_w(CH_DISP);
    localparam int UDEVW  = fld_w(CH_UDEV);
    localparam logic [DISPW-1:0] DISP_FLOOR = DISP_MIN_FIELD[DISPW-1:0];

    logic              aud_src, udev_src, ser_src, half_q;
    logic [AUDW-1:0]   aud_div;
    logic [SERW-1:0]   ser_div;
    logic [PIXW-1:0]   pix_div;
    logic [CARDW-1:0]  card_div;
    logic [UHOSTW-1:0] uhost_div;
    logic [DISPW-1:0]  disp_div;
    logic [UDEVW-1:0]  udev_div;
    logic [GW-1:0]     gate_nxt;
    logic [DISPW-1:0]  disp_in, disp_cl;
    logic [DW-1:0]     ctrl_word;
    reg_addr_e         waddr, raddr;

    assign waddr = reg_addr_e'(wr_addr);
    assign raddr = reg_addr_e'(rd_addr);

    // display field clamp toward the floor
    assign disp_in = wr_data[L_DISP +: DISPW];
    assign disp_cl = (disp_in < DISP_FLOOR) ? DISP_FLOOR : disp_in;

    // gate word: software write first, then suspend / resume override
    always_comb begin
        gate_nxt = gate_q;
        if (wr_en && waddr == RA_GATE)
            gate_nxt = wr_data[GW-1:0];
        if (suspend_req)
            gate_nxt = gate_nxt | SLEEP_SET;
        else if (resume_req)
            gate_nxt = gate_nxt & ~SLEEP_SET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aud_src   <= 1'b0;
            udev_src  <= 1'b0;
            ser_src   <= 1'b0;
            half_q    <= 1'b0;
            aud_div   <= '0;
            ser_div   <= '0;
            pix_div   <= '0;
            card_div  <= '0;
            uhost_div <= '0;
            disp_div  <= DISP_FLOOR;
            udev_div  <= '0;
            gate_q    <= '0;
        end else begin
            gate_q <= gate_nxt;
            if (wr_en) begin
                case (waddr)
                    RA_CTRL: begin
                        aud_src  <= wr_data[B_AUD_SRC];
                        udev_src <= wr_data[B_UDEV_SRC];
                        half_q   <= wr_data[B_HALF_FULL];
                        udev_div <= wr_data[L_UDEV +: UDEVW];
                        disp_div <= disp_cl;
                    end
                    RA_AUD:   aud_div   <= wr_data[AUDW-1:0];
                    RA_SER: begin
                        ser_div <= wr_data[SERW-1:0];
                        ser_src <= wr_data[B_SER_SRC];
                    end
                    RA_PIX:   pix_div   <= wr_data[PIXW-1:0];
                    RA_CARD:  card_div  <= wr_data[CARDW-1:0];
                    RA_UHOST: uhost_div <= wr_data[UHOSTW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[B_AUD_SRC]        = aud_src;
        ctrl_word[B_UDEV_SRC]       = udev_src;
        ctrl_word[L_UDEV +: UDEVW]  = udev_div;
        ctrl_word[B_HALF_FULL]      = half_q;
        ctrl_word[L_DISP +: DISPW]  = disp_div;
    end

    always_comb begin
        rd_data = '0;
        case (raddr)
            RA_CTRL:  rd_data = ctrl_word;
            RA_GATE:  rd_data[GW-1:0] = gate_q;
            RA_AUD:   rd_data[AUDW-1:0] = aud_div;
            RA_SER: begin
                rd_data[SERW-1:0] = ser_div;
                rd_data[B_SER_SRC] = ser_src;
            end
            RA_PIX:   rd_data[PIXW-1:0] = pix_div;
            RA_CARD:  rd_data[CARDW-1:0] = card_div;
            RA_UHOST: rd_data[UHOSTW-1:0] = uhost_div;
            default:  rd_data = '0;
        endcase
    end

    // per-channel configuration
    always_comb begin
        cfg[CH_AUD].pll_src   = aud_src;
        cfg[CH_AUD].field     = FMAX'(aud_div);
        cfg[CH_SER].pll_src   = ser_src;
        cfg[CH_SER].field     = FMAX'(ser_div);
        cfg[CH_PIX].pll_src   = 1'b1;
        cfg[CH_PIX].field     = FMAX'(pix_div);
        cfg[CH_CARD].pll_src  = 1'b1;
        cfg[CH_CARD].field    = FMAX'(card_div);
        cfg[CH_UHOST].pll_src = 1'b1;
        cfg[CH_UHOST].field   = FMAX'(uhost_div);
        cfg[CH_DISP].pll_src  = 1'b1;
        cfg[CH_DISP].field    = FMAX'(disp_div);
        cfg[CH_UDEV].pll_src  = udev_src;
        cfg[CH_UDEV].field    = FMAX'(udev_div);
        for (int i = 0; i < NCH; i++)
            cfg[i].gated = |(gate_q & gate_mask(i));
    end

    assign half_full = half_q;

endmodule

// File: rtl/pclk_half.sv
module pclk_half (
    input  logic clk,
    input  logic rst,
    input  logic pll_tick,
    input  logic full_sel,
    output logic half_tick
);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= 1'b0;
        else if (pll_tick)
            phase <= ~phase;
    end

    // full_sel = 1: every PLL tick; 0: every second PLL tick
    assign half_tick = pll_tick & (full_sel | phase);

endmodule

// File: rtl/pclk_chan.sv
module pclk_chan #(
    parameter int FW    = 4,
    parameter bit FIXED = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_tick,
    input  logic          half_tick,
    input  logic          pll_src,
    input  logic          gated,
    input  logic [FW-1:0] field,
    output logic          en
);

    logic          sel_r, hold, seen_ref, seen_half;
    logic [FW-1:0] cnt, div_act;
    logic          terminal, src_pulse, both_seen;

    assign terminal  = (cnt == div_act);
    assign src_pulse = sel_r ? (half_tick && terminal) : ref_tick;
    assign both_seen = (seen_ref || ref_tick) && (seen_half || half_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_r     <= FIXED;
            hold      <= 1'b0;
            seen_ref  <= 1'b0;
            seen_half <= 1'b0;
            cnt       <= '0;
            div_act   <= '0;
            en        <= 1'b0;
        end else begin
            en <= !gated && !hold && (pll_src == sel_r) && src_pulse;
            if (pll_src != sel_r) begin
                // source switch: go quiet until both sources have ticked
                sel_r     <= pll_src;
                hold      <= 1'b1;
                seen_ref  <= 1'b0;
                seen_half <= 1'b0;
                cnt       <= '0;
            end else if (hold) begin
                if (both_seen) begin
                    hold      <= 1'b0;
                    seen_ref  <= 1'b0;
                    seen_half <= 1'b0;
                    cnt       <= '0;
                    div_act   <= field;
                end else begin
                    seen_ref  <= seen_ref | ref_tick;
                    seen_half <= seen_half | half_tick;
                end
            end else if (!sel_r) begin
                cnt     <= '0;
                div_act <= field;
            end else if (half_tick) begin
                if (terminal) begin
                    cnt     <= '0;
                    div_act <= field;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import pclk_pkg::*;
#(
    parameter int DISP_MIN_FIELD = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pll_tick,
    input  logic          ref_tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic          suspend_req,
    input  logic          resume_req,
    output logic [6:0]    pclk_en,
    output logic [15:0]   clk_run
);

    logic                 half_full, half_tick;
    logic [GW-1:0]        gate_q;
    chan_cfg_t [NCH-1:0]  cfg;

    pclk_regs #(.DISP_MIN_FIELD(DISP_MIN_FIELD)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .half_full   (half_full),
        .gate_q      (gate_q),
        .cfg         (cfg)
    );

    pclk_half u_half (
        .clk       (clk),
        .rst       (rst),
        .pll_tick  (pll_tick),
        .full_sel  (half_full),
        .half_tick (half_tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int W = fld_w(g);
        pclk_chan #(.FW(W), .FIXED(fixed_pll(g))) u_ch (
            .clk       (clk),
            .rst       (rst),
            .ref_tick  (ref_tick),
            .half_tick (half_tick),
            .pll_src   (cfg[g].pll_src),
            .gated     (cfg[g].gated),
            .field     (cfg[g].field[W-1:0]),
            .en        (pclk_en[g])
        );
    end

    assign clk_run = ~gate_q;

endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk
    import pclk_pkg::*;
#(
    parameter int DISP_MIN_FIELD = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                suspend_req,
    input logic                resume_req,
    input logic [GW-1:0]       gate_q,
    input chan_cfg_t [NCH-1:0] cfg,
    input logic [NCH-1:0]      pclk_en
);

    // R8: suspend sets the grouped gate bits
    a_r8_suspend_sets: assert property (@(posedge clk) disable iff (rst)
        suspend_req |=> ((gate_q & SLEEP_SET) == SLEEP_SET));

    // R8: resume alone clears the grouped gate bits
    a_r8_resume_clears: assert property (@(posedge clk) disable iff (rst)
        (resume_req && !suspend_req) |=> ((gate_q & SLEEP_SET) == '0));

    // R6: a set gate bit silences the channel on the next cycle
    a_r6_card_gated: assert property (@(posedge clk) disable iff (rst)
        gate_q[7] |=> !pclk_en[CH_CARD]);

    a_r6_audio_gated: assert property (@(posedge clk) disable iff (rst)
        gate_q[6] |=> !pclk_en[CH_AUD]);

    // R5: display field never below its floor
    a_r5_disp_floor: assert property (@(posedge clk) disable iff (rst)
        cfg[CH_DISP].field[4:0] >= 5'(DISP_MIN_FIELD));

    // R9: a source change is followed by a quiet cycle
    a_r9_switch_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg[CH_AUD].pll_src != $past(cfg[CH_AUD].pll_src)) |=> !pclk_en[CH_AUD]);

    a_r9_udev_switch_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg[CH_UDEV].pll_src != $past(cfg[CH_UDEV].pll_src)) |=> !pclk_en[CH_UDEV]);

endmodule

bind pclk_gen pclk_gen_chk #(.DISP_MIN_FIELD(DISP_MIN_FIELD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .gate_q      (gate_q),
    .cfg         (cfg),
    .pclk_en     (pclk_en)
);

// File: tb/test_pclk_gen.sv
module test_pclk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pll_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        suspend_req = 1'b0;
    logic        resume_req = 1'b0;
    logic [6:0]  pclk_en;
    logic [15:0] clk_run;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int refcnt = 0;

    pclk_gen i_pclk_gen (
        .clk(clk), .rst(rst), .pll_tick(pll_tick), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .pclk_en(pclk_en), .clk_run(clk_run)
    );

    initial forever #2ns clk = ~clk;
    initial forever @(posedge clk) cyc <= cyc + 1;

    // reference tick: one pulse every 5 cycles
    initial forever @(negedge clk) begin
        refcnt   <= (refcnt == 4) ? 0 : refcnt + 1;
        ref_tick <= (refcnt == 4);
    end

    typedef struct packed {
        logic [31:0] ctrl;
        logic [2:0]  daddr;
        logic [31:0] ddata;
        logic [2:0]  ch;
        logic [7:0]  per;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{32'h0000_0000, 3'd4, 32'd3,          3'd2, 8'd8},   // R1 pixel, half/2
        '{32'h0020_0000, 3'd4, 32'd3,          3'd2, 8'd4},   // R2 pixel, full
        '{32'h0020_0000, 3'd5, 32'd5,          3'd3, 8'd6},   // R1 card
        '{32'h0000_0000, 3'd6, 32'd15,         3'd4, 8'd32},  // R1 usb host max
        '{32'h8020_0000, 3'd2, 32'd2,          3'd0, 8'd3},   // R3 audio on pll
        '{32'h0020_0000, 3'd2, 32'd2,          3'd0, 8'd5},   // R3 audio bypass
        '{32'h0020_0000, 3'd3, 32'h8000_0009,  3'd1, 8'd10},  // R3 serial on pll
        '{32'h0020_0000, 3'd3, 32'd9,          3'd1, 8'd5},   // R3 serial bypass
        '{32'h2220_0000, 3'd0, 32'd0,          3'd6, 8'd5},   // R4 usb device field
        '{32'h0026_0000, 3'd0, 32'd0,          3'd5, 8'd7},   // R5 display field 6
        '{32'h0020_0000, 3'd0, 32'd0,          3'd5, 8'd2}    // R5 display clamp
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1ns wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1ns d = rd_data;
    endtask

    task automatic wait_pulse(input int ch, output int t);
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pclk_en[ch]) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic measure(input int ch, output int p);
        int t0, t1;
        wait_pulse(ch, t0);
        wait_pulse(ch, t0);
        wait_pulse(ch, t0);
        wait_pulse(ch, t1);
        p = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
    endtask

    task automatic count_pulses(input int ch, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pclk_en[ch]) k++;
        end
    endtask

    task automatic pulse_req(input bit sus, input bit res);
        @(negedge clk);
        suspend_req = sus; resume_req = res;
        @(posedge clk);
        #1ns suspend_req = 1'b0; resume_req = 1'b0;
    endtask

    initial begin
        #(4ns * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int p, k, t0, t1, t2;

        repeat (3) @(posedge clk);
        #1ns;
        // R11 reset state
        chk("R11 pclk_en in reset", {25'd0, pclk_en}, 32'd0);
        chk("R11 clk_run in reset", {16'd0, clk_run}, 32'h0000_FFFF);
        rst = 1'b0;
        pll_tick = 1'b1;
        do_read(3'd0, d); chk("R11 ctrl after reset", d, 32'h0001_0000);
        do_read(3'd1, d); chk("R11 gate after reset", d, 32'd0);
        do_read(3'd2, d); chk("R11 audio div after reset", d, 32'd0);
        do_read(3'd7, d); chk("R4 unused address", d, 32'd0);

        // table of period vectors (R1 R2 R3 R4 R5)
        for (int v = 0; v < 11; v++) begin
            do_write(3'd0, VECS[v].ctrl);
            if (VECS[v].daddr != 3'd0) do_write(VECS[v].daddr, VECS[v].ddata);
            measure(int'(VECS[v].ch), p);
            chk($sformatf("R1/R2/R3 period vector %0d", v), p, {24'd0, VECS[v].per});
        end

        // R4 truncation
        do_write(3'd2, 32'h0000_FFFF);
        do_read(3'd2, d); chk("R4 audio field truncation", d, 32'h0000_01FF);
        do_write(3'd6, 32'h0000_00FF);
        do_read(3'd6, d); chk("R4 usb host field truncation", d, 32'h0000_000F);
        do_write(3'd3, 32'h8000_00F3);
        do_read(3'd3, d); chk("R4 serial word readback", d, 32'h8000_0003);

        // R5 clamp readback
        do_write(3'd0, 32'h0020_0000);
        do_read(3'd0, d); chk("R5 display clamp readback", d, 32'h0021_0000);

        // R10 reload at terminal count: pixel field 15, full rate
        do_write(3'd4, 32'd15);
        measure(2, p);
        chk("R10 pixel period before change", p, 32'd16);
        wait_pulse(2, t0);
        do_write(3'd4, 32'd1);
        wait_pulse(2, t1);
        wait_pulse(2, t2);
        chk("R10 period in progress kept", t1 - t0, 32'd16);
        chk("R10 new period after terminal", t2 - t1, 32'd2);

        // R12 output follows reference tick by one cycle (audio on ext)
        do_write(3'd2, 32'd2);
        repeat (12) @(negedge clk);
        k = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pclk_en[0] !== ref_tick) k++;
        end
        chk("R12 one-cycle latency mismatches", k, 32'd0);

        // R9 quiet after source switch
        do_write(3'd0, 32'h8020_0000);
        @(negedge clk);
        @(negedge clk); chk("R9 quiet cycle 1 after switch", {31'd0, pclk_en[0]}, 32'd0);
        @(negedge clk); chk("R9 quiet cycle 2 after switch", {31'd0, pclk_en[0]}, 32'd0);
        measure(0, p);
        chk("R9 period after switch settles", p, 32'd3);

        // R6 gate card
        do_write(3'd1, 32'h0000_0080);
        count_pulses(3, 60, k);
        chk("R6 gated card silent", k, 32'd0);
        chk("R6 clk_run inverse", {16'd0, clk_run}, 32'h0000_FF7F);
        do_write(3'd1, 32'h0000_0000);
        count_pulses(3, 60, k);
        chk("R6 ungated card runs", {31'd0, k > 0}, 32'd1);

        // R7 pixel ignores gate
        do_write(3'd1, 32'h0000_FFFF);
        measure(2, p);
        chk("R7 pixel runs when all gated", p, 32'd2);
        count_pulses(0, 60, k);
        chk("R6 audio silent when all gated", k, 32'd0);

        // R8 suspend / resume
        do_write(3'd1, 32'h0000_0040);
        pulse_req(1'b1, 1'b0);
        do_read(3'd1, d); chk("R8 suspend sets group", d, 32'h0000_1043);
        pulse_req(1'b0, 1'b1);
        do_read(3'd1, d); chk("R8 resume clears group", d, 32'h0000_0040);
        pulse_req(1'b1, 1'b1);
        do_read(3'd1, d); chk("R8 suspend wins", d, 32'h0000_1043);
        chk("R8 clk_run after suspend", {16'd0, clk_run}, 32'h0000_EFBC);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule